// File: doc/BRIEF.md
# SPI Register Port with Buffered Update

This block is the serial control port of a clock-generator control register space. An SPI master sends a 16-bit instruction word, then one to three data bytes. The instruction says whether the access reads or writes, how many data bytes follow, and which register the first byte addresses. The SPI pins are oversampled in the system clock domain, so SCLK is treated as data rather than as a clock.

Register writes that control the clock path do not take effect at once. They land in a shadow bank. A self-clearing update bit copies the whole shadow bank into the active bank in one clock cycle. The active bank drives the block's outputs: a window of general-purpose configuration bytes and three power-down controls. A readback-select bit chooses which bank a read returns.

The port configuration register holds two controls. One is a self-clearing soft reset that clears every register. The other chooses where read data is driven: on the bidirectional data pin (3-wire) or on a separate data-out pin (4-wire).

Top module: `spi_shadow_regs`

## Requirements
- R1: Instruction bit 15 selects read (1) or write (0). Bits 14:13 hold the data byte count minus one. Bits 11:0 hold the address. Bit 12 has no effect on the access.
- R2: Data bytes are shifted MSB first. The address decreases by one after each byte. Count field 3 gives three bytes. Bytes beyond the count are neither written nor driven, and read as zero.
- R3: Writes go only to the shadow bank. The shadow bank covers the power-down register at 0x233 (bit 2 and bit 1 are the two PLL power-downs, bit 0 is the distribution power-down) and the window of GEN_BYTES bytes starting at GEN_BASE. The active outputs change only on an update or a soft reset.
- R4: Writing 1 to bit 0 of address 0x234 copies the whole shadow bank to the active bank one clock after the byte is committed. The update bit then clears itself and reads as zero.
- R5: Bit 0 of address 0x004 selects what reads of buffered registers return: 1 returns shadow values, 0 returns active values.
- R6: Writing 1 to bit 5 of address 0x000 clears all registers in the next clock, including shadow, active, mode and readback select. The bit then clears itself.
- R7: Bit 7 of address 0x000 selects 4-wire mode when 1 and 3-wire mode when 0. In 4-wire mode read data appears on sdo_o with sdo_oe. In 3-wire mode it appears on sdio_o with sdio_oe. Each output enable is high only during the counted data bytes of a read, and never on both pins at once.
- R8: Raising chip select discards a partly shifted byte. This holds even when chip select rises in the same cycle as the eighth SCLK rising edge. Register contents are unchanged.
- R9: Addresses outside the registers above read as zero, and writes to them have no effect.
- R10: After reset every register is zero, the active outputs are zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, SPI mode 0 |
| sdio_i | input | 1 | Serial data in (instruction and write data) |
| sdio_o | output | 1 | Read data on the bidirectional pin in 3-wire mode |
| sdio_oe | output | 1 | Output enable of the bidirectional pin |
| sdo_o | output | 1 | Read data on the separate pin in 4-wire mode |
| sdo_oe | output | 1 | Output enable of the separate data-out pin |
| act_gen_o | output | GEN_BYTES*8 | Active general bytes, byte i at bits 8i+7:8i |
| pwr_down_o | output | 3 | Active power-down controls |

## Verification
The release of chip select and the eighth rising SCLK edge of a byte can be detected in the same system clock cycle, because both pass through synchronizers of equal depth. The bench provokes this by raising SCLK and chip select on the same clock edge while writing the complement of a stored byte. It then applies an update and reads the byte back. The byte must be unchanged, which shows that chip select wins over the commit. The bench also checks that a later ordinary write to the same address succeeds, which shows that the framing logic returned to idle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned AW         = 12;
  localparam int unsigned INSTR_BITS = 16;

  localparam logic [AW-1:0] A_PORTCFG = 12'h000;
  localparam logic [AW-1:0] A_RDSEL   = 12'h004;
  localparam logic [AW-1:0] A_PWRDN   = 12'h233;
  localparam logic [AW-1:0] A_UPDATE  = 12'h234;

  localparam int unsigned B_SRST = 5;
  localparam int unsigned B_4W   = 7;

  typedef struct packed {
    logic          rd;
    logic [1:0]    cnt_m1;
    logic          rsv;
    logic [AW-1:0] addr;
  } instr_t;

  function automatic logic [1:0] data_len(input logic [1:0] f);
    return (f == 2'd3) ? 2'd3 : f + 2'd1;
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned    W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {3{RST_VAL[g]}};
      else        st_q <= {st_q[1:0], async_i[g]};
    end
    assign lvl_o[g]  = st_q[1];
    assign rise_o[g] = st_q[1] & ~st_q[2];
  end
endmodule

// File: rtl/ssr_frame.sv
module ssr_frame
  import ssr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csn_s,
  input  logic          sclk_rise,
  input  logic          din,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          tx_bit,
  output logic          rd_phase
);
  logic [3:0]    bit_q, bit_d;
  logic          in_data_q, in_data_d;
  logic [1:0]    byte_q, byte_d;
  logic [1:0]    nbytes_q, nbytes_d;
  logic          is_rd_q, is_rd_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [14:0]   sh_q, sh_d;
  logic [7:0]    tx_q, tx_d;
  logic [15:0]   rx_word;
  instr_t        instr;
  logic          unused_rsv;

  assign rx_word    = {sh_q, din};
  assign instr      = instr_t'(rx_word);
  assign unused_rsv = instr.rsv;

  always_comb begin
    bit_d     = bit_q;
    in_data_d = in_data_q;
    byte_d    = byte_q;
    nbytes_d  = nbytes_q;
    is_rd_d   = is_rd_q;
    addr_d    = addr_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    wr_en     = 1'b0;
    wr_addr   = addr_q;
    wr_data   = rx_word[7:0];
    rd_addr   = in_data_q ? addr_q - AW'(1) : instr.addr;
    if (csn_s) begin
      bit_d     = '0;
      in_data_d = 1'b0;
      byte_d    = '0;
      tx_d      = '0;
    end else if (sclk_rise) begin
      sh_d  = rx_word[14:0];
      bit_d = bit_q + 4'd1;
      if (!in_data_q) begin
        if (bit_q == 4'(INSTR_BITS - 1)) begin
          in_data_d = 1'b1;
          bit_d     = '0;
          byte_d    = '0;
          is_rd_d   = instr.rd;
          nbytes_d  = data_len(instr.cnt_m1);
          addr_d    = instr.addr;
          tx_d      = rd_data;
        end
      end else if (bit_q == 4'd7) begin
        bit_d  = '0;
        wr_en  = !is_rd_q && (byte_q < nbytes_q);
        addr_d = addr_q - AW'(1);
        if (byte_q != 2'd3) byte_d = byte_q + 2'd1;
        tx_d = (({1'b0, byte_q} + 3'd1) < {1'b0, nbytes_q}) ? rd_data : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      in_data_q <= 1'b0;
      byte_q    <= '0;
      nbytes_q  <= '0;
      is_rd_q   <= 1'b0;
      addr_q    <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
    end else begin
      bit_q     <= bit_d;
      in_data_q <= in_data_d;
      byte_q    <= byte_d;
      nbytes_q  <= nbytes_d;
      is_rd_q   <= is_rd_d;
      addr_q    <= addr_d;
      sh_q      <= sh_d;
      tx_q      <= tx_d;
    end
  end

  assign tx_bit   = tx_q[3'd7 - bit_q[2:0]];
  assign rd_phase = !csn_s && in_data_q && is_rd_q && (byte_q < nbytes_q);

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_data_q |-> (bit_q < 4'd8)); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (!in_data_q && bit_q == 4'd0)); // R8
endmodule

// File: rtl/ssr_bank.sv
module ssr_bank
  import ssr_pkg::*;
#(
  parameter int unsigned GEN_BASE  = 16,
  parameter int unsigned GEN_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [7:0]             rd_data,
  output logic                   four_wire,
  output logic [GEN_BYTES*8-1:0] act_gen_o,
  output logic [2:0]             act_pwr_o
);
  localparam int unsigned IDX_W = (GEN_BYTES > 1) ? $clog2(GEN_BYTES) : 1;
  localparam logic [AW-1:0] BASE = AW'(GEN_BASE);
  localparam logic [AW-1:0] SPAN = AW'(GEN_BYTES);

  typedef logic [GEN_BYTES-1:0][7:0] bank_t;

  bank_t      shd_gen_q, shd_gen_d, act_gen_q, act_gen_d;
  logic [2:0] shd_pwr_q, shd_pwr_d, act_pwr_q, act_pwr_d;
  logic       four_q, four_d, srst_q, srst_d, rdsel_q, rdsel_d, upd_q, upd_d;
  logic [AW-1:0]    wr_off, rd_off;
  logic             wr_hit, rd_hit;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_off = wr_addr - BASE;
  assign rd_off = rd_addr - BASE;
  assign wr_hit = wr_off < SPAN;
  assign rd_hit = rd_off < SPAN;
  assign wr_idx = wr_off[IDX_W-1:0];
  assign rd_idx = rd_off[IDX_W-1:0];

  always_comb begin
    shd_gen_d = shd_gen_q;
    act_gen_d = act_gen_q;
    shd_pwr_d = shd_pwr_q;
    act_pwr_d = act_pwr_q;
    four_d    = four_q;
    rdsel_d   = rdsel_q;
    srst_d    = 1'b0;
    upd_d     = 1'b0;
    if (srst_q) begin
      shd_gen_d = '0;
      act_gen_d = '0;
      shd_pwr_d = '0;
      act_pwr_d = '0;
      four_d    = 1'b0;
      rdsel_d   = 1'b0;
    end else begin
      if (upd_q) begin
        act_gen_d = shd_gen_q;
        act_pwr_d = shd_pwr_q;
      end
      if (wr_en) begin
        if (wr_addr == A_PORTCFG) begin
          four_d = wr_data[B_4W];
          srst_d = wr_data[B_SRST];
        end
        if (wr_addr == A_RDSEL)  rdsel_d   = wr_data[0];
        if (wr_addr == A_PWRDN)  shd_pwr_d = wr_data[2:0];
        if (wr_addr == A_UPDATE) upd_d     = wr_data[0];
        if (wr_hit)              shd_gen_d[wr_idx] = wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == A_PORTCFG) rd_data = {four_q, 1'b0, srst_q, 5'b0};
    if (rd_addr == A_RDSEL)   rd_data = {7'b0, rdsel_q};
    if (rd_addr == A_PWRDN)   rd_data = {5'b0, rdsel_q ? shd_pwr_q : act_pwr_q};
    if (rd_hit)               rd_data = rdsel_q ? shd_gen_q[rd_idx] : act_gen_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_gen_q <= '0;
      act_gen_q <= '0;
      shd_pwr_q <= '0;
      act_pwr_q <= '0;
      four_q    <= 1'b0;
      srst_q    <= 1'b0;
      rdsel_q   <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      shd_gen_q <= shd_gen_d;
      act_gen_q <= act_gen_d;
      shd_pwr_q <= shd_pwr_d;
      act_pwr_q <= act_pwr_d;
      four_q    <= four_d;
      srst_q    <= srst_d;
      rdsel_q   <= rdsel_d;
      upd_q     <= upd_d;
    end
  end

  assign four_wire = four_q;
  assign act_gen_o = act_gen_q;
  assign act_pwr_o = act_pwr_q;

  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q); // R4
  AST_UPD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !srst_q) |=> (act_gen_q == $past(shd_gen_q) && act_pwr_q == $past(shd_pwr_q))); // R4
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_gen_q) || !$stable(act_pwr_q)) |-> $past(upd_q || srst_q)); // R3
  AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (act_gen_q == '0 && shd_gen_q == '0 && act_pwr_q == '0 && !four_q && !rdsel_q && !srst_q)); // R6
endmodule

// File: rtl/spi_shadow_regs.sv
module spi_shadow_regs
  import ssr_pkg::*;
#(
  parameter int unsigned GEN_BASE  = 16,
  parameter int unsigned GEN_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_csn,
  input  logic                   spi_sclk,
  input  logic                   sdio_i,
  output logic                   sdio_o,
  output logic                   sdio_oe,
  output logic                   sdo_o,
  output logic                   sdo_oe,
  output logic [GEN_BYTES*8-1:0] act_gen_o,
  output logic [2:0]             pwr_down_o
);
  logic [1:0]    rst_pipe;
  logic          rst_n_i;
  logic [2:0]    sync_lvl, sync_rise;
  logic          unused_rise;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          wr_en, tx_bit, rd_phase, four_wire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  ssr_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .async_i ({sdio_i, spi_sclk, spi_csn}),
    .lvl_o   (sync_lvl),
    .rise_o  (sync_rise)
  );
  assign unused_rise = sync_rise[0] ^ sync_rise[2];

  ssr_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .csn_s     (sync_lvl[0]),
    .sclk_rise (sync_rise[1]),
    .din       (sync_lvl[2]),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tx_bit    (tx_bit),
    .rd_phase  (rd_phase)
  );

  ssr_bank #(.GEN_BASE(GEN_BASE), .GEN_BYTES(GEN_BYTES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .four_wire (four_wire),
    .act_gen_o (act_gen_o),
    .act_pwr_o (pwr_down_o)
  );

  assign sdio_oe = rd_phase && !four_wire;
  assign sdo_oe  = rd_phase && four_wire;
  assign sdio_o  = sdio_oe && tx_bit;
  assign sdo_o   = sdo_oe && tx_bit;

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(sdio_oe && sdo_oe)); // R7
endmodule

// File: tb/test_spi_shadow_regs.sv
module test_spi_shadow_regs;
  localparam int GBASE = 16;
  localparam int GB    = 16;
  localparam int HALF  = 4;

  logic clk, rst_n, spi_csn, spi_sclk, sdio_i;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [GB*8-1:0] act_gen_o;
  logic [2:0] pwr_down_o;

  spi_shadow_regs #(.GEN_BASE(GBASE), .GEN_BYTES(GB)) i_spi_shadow_regs (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .act_gen_o(act_gen_o), .pwr_down_o(pwr_down_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic fourw = 1'b0;
  logic [7:0] exp_shd [GB];
  logic [7:0] exp_act [GB];
  logic [2:0] exp_pshd, exp_pact;

  task automatic check(input string req, input string what, input logic [GB*8-1:0] act, input logic [GB*8-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [GB*8-1:0] exp_bus();
    logic [GB*8-1:0] v = '0;
    for (int i = 0; i < GB; i++) v[8*i +: 8] = exp_act[i];
    return v;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ 8'hA5);
  endfunction

  task automatic spi_bit(input logic b, output logic rb, output logic o3, output logic o4);
    @(negedge clk) sdio_i = b;
    repeat (HALF) @(negedge clk);
    rb = fourw ? sdo_o : sdio_o;
    o3 = sdio_oe;
    o4 = sdo_oe;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic spi_xfer(input logic rd, input logic [1:0] cf, input logic b12, input logic [11:0] a,
                          input int nb, input logic [23:0] wd, output logic [23:0] rdv, output int oe_err);
    logic [15:0] ins;
    logic rb, o3, o4, e;
    int eff;
    ins = {rd, cf, b12, a};
    eff = (cf == 2'd3) ? 3 : int'(cf) + 1;
    rdv = '0;
    oe_err = 0;
    @(negedge clk) spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 15; k >= 0; k--) begin
      spi_bit(ins[k], rb, o3, o4);
      if (o3 || o4) oe_err++;
    end
    for (int i = 0; i < nb; i++) begin
      for (int j = 7; j >= 0; j--) begin
        spi_bit(wd[8*(nb-1-i)+j], rb, o3, o4);
        rdv = {rdv[22:0], rb};
        e = rd && (i < eff);
        if ((fourw ? o4 : o3) != e || (fourw ? o3 : o4)) oe_err++;
      end
    end
    @(negedge clk) spi_csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    logic [23:0] rv;
    int oe;
    spi_xfer(1'b0, 2'd0, 1'b0, a, 1, {16'h0, d}, rv, oe);
  endtask

  task automatic do_update();
    wr(12'h234, 8'h01);
    for (int i = 0; i < GB; i++) exp_act[i] = exp_shd[i];
    exp_pact = exp_pshd;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
    logic [23:0] rv;
    int oe;
    spi_xfer(1'b1, 2'd0, 1'b0, a, 1, 24'h0, rv, oe);
    check(req, $sformatf("read %0h", a), {{(GB*8-8){1'b0}}, rv[7:0]}, {{(GB*8-8){1'b0}}, exp});
    check("R7", "output enable during read", {{(GB*8-32){1'b0}}, 32'(oe)}, '0);
  endtask

  task automatic spi_abort(input logic [11:0] a, input logic [7:0] d, input int nbits, input logic same);
    logic [15:0] ins;
    logic rb, o3, o4;
    ins = {1'b0, 2'd0, 1'b0, a};
    @(negedge clk) spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 15; k >= 0; k--) spi_bit(ins[k], rb, o3, o4);
    for (int j = 0; j < nbits; j++) spi_bit(d[7-j], rb, o3, o4);
    if (same) begin
      @(negedge clk) sdio_i = d[7-nbits];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      spi_csn  = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end else begin
      @(negedge clk) spi_csn = 1'b1;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] rv;
    int oe;
    for (int i = 0; i < GB; i++) begin exp_shd[i] = '0; exp_act[i] = '0; end
    exp_pshd = '0;
    exp_pact = '0;
    rst_n = 1'b0; spi_csn = 1'b1; spi_sclk = 1'b0; sdio_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check("R10", "active bytes", act_gen_o, '0);
    check("R10", "power-down", {{(GB*8-3){1'b0}}, pwr_down_o}, '0);
    check("R10", "output enables", {{(GB*8-2){1'b0}}, sdio_oe, sdo_oe}, '0);
    rd_chk("R10", 12'h000, 8'h00);

    // R3 R5: fill shadow bank, active must stay put
    wr(12'h004, 8'h01);
    rd_chk("R5", 12'h004, 8'h01);
    for (int i = 0; i < GB; i++) begin
      wr(12'(GBASE + i), pat(i));
      exp_shd[i] = pat(i);
    end
    check("R3", "active before update", act_gen_o, exp_bus());
    for (int i = 0; i < GB; i++) rd_chk("R5", 12'(GBASE + i), exp_shd[i]);
    wr(12'h004, 8'h00);
    for (int i = 0; i < GB; i++) rd_chk("R5", 12'(GBASE + i), exp_act[i]);

    // R4 update copies whole bank, bit reads zero
    do_update();
    check("R4", "active after update", act_gen_o, exp_bus());
    rd_chk("R4", 12'h234, 8'h00);
    for (int i = 0; i < GB; i++) rd_chk("R4", 12'(GBASE + i), exp_act[i]);

    // R3 power-down register buffered
    wr(12'h233, 8'h05);
    exp_pshd = 3'd5;
    check("R3", "power-down before update", {{(GB*8-3){1'b0}}, pwr_down_o}, {{(GB*8-3){1'b0}}, exp_pact});
    rd_chk("R3", 12'h233, {5'b0, exp_pact});
    do_update();
    check("R3", "power-down after update", {{(GB*8-3){1'b0}}, pwr_down_o}, {{(GB*8-3){1'b0}}, exp_pact});

    // R2 multi-byte, descending address, count field 3, extra bytes
    spi_xfer(1'b0, 2'd2, 1'b0, 12'(GBASE + 5), 3, 24'hA1B2C3, rv, oe);
    exp_shd[5] = 8'hA1; exp_shd[4] = 8'hB2; exp_shd[3] = 8'hC3;
    spi_xfer(1'b0, 2'd3, 1'b0, 12'(GBASE + 12), 3, 24'h112233, rv, oe);
    exp_shd[12] = 8'h11; exp_shd[11] = 8'h22; exp_shd[10] = 8'h33;
    spi_xfer(1'b0, 2'd0, 1'b0, 12'(GBASE + 9), 2, 24'h007788, rv, oe);
    exp_shd[9] = 8'h77;
    do_update();
    check("R2", "multi-byte writes", act_gen_o, exp_bus());
    spi_xfer(1'b1, 2'd1, 1'b0, 12'(GBASE + 5), 2, 24'h0, rv, oe);
    check("R2", "two-byte read", {{(GB*8-16){1'b0}}, rv[15:0]}, {{(GB*8-16){1'b0}}, exp_act[5], exp_act[4]});
    check("R7", "oe two-byte read", {{(GB*8-32){1'b0}}, 32'(oe)}, '0);
    spi_xfer(1'b1, 2'd0, 1'b0, 12'(GBASE + 9), 2, 24'h0, rv, oe);
    check("R2", "byte beyond count", {{(GB*8-16){1'b0}}, rv[15:0]}, {{(GB*8-16){1'b0}}, exp_act[9], 8'h00});
    check("R2", "oe beyond count", {{(GB*8-32){1'b0}}, 32'(oe)}, '0);

    // R9 unimplemented space; read across the window's lower edge
    wr(12'h100, 8'hFF);
    wr(12'hFFF, 8'hFF);
    do_update();
    check("R9", "active after stray writes", act_gen_o, exp_bus());
    rd_chk("R9", 12'h100, 8'h00);
    spi_xfer(1'b1, 2'd1, 1'b0, 12'(GBASE), 2, 24'h0, rv, oe);
    check("R9", "read below window", {{(GB*8-16){1'b0}}, rv[15:0]}, {{(GB*8-16){1'b0}}, exp_act[0], 8'h00});

    // R1 reserved bit 12 ignored
    spi_xfer(1'b0, 2'd0, 1'b1, 12'(GBASE + 1), 1, 24'h00003C, rv, oe);
    exp_shd[1] = 8'h3C;
    do_update();
    check("R1", "write with bit 12 set", act_gen_o, exp_bus());

    // R7 4-wire mode
    wr(12'h000, 8'h80);
    fourw = 1'b1;
    rd_chk("R7", 12'h000, 8'h80);
    rd_chk("R7", 12'(GBASE + 3), exp_act[3]);

    // R8 abort, plain and same-cycle with last edge
    spi_abort(12'(GBASE + 2), ~exp_shd[2], 5, 1'b0);
    spi_abort(12'(GBASE + 2), ~exp_shd[2], 7, 1'b1);
    do_update();
    check("R8", "aborted bytes discarded", act_gen_o, exp_bus());
    rd_chk("R8", 12'(GBASE + 2), exp_act[2]);
    wr(12'(GBASE + 2), 8'h99);
    exp_shd[2] = 8'h99;
    do_update();
    check("R8", "write after abort", act_gen_o, exp_bus());

    // R6 soft reset
    wr(12'h000, 8'h20);
    fourw = 1'b0;
    for (int i = 0; i < GB; i++) begin exp_shd[i] = '0; exp_act[i] = '0; end
    exp_pshd = '0;
    exp_pact = '0;
    check("R6", "active after soft reset", act_gen_o, '0);
    check("R6", "power-down after soft reset", {{(GB*8-3){1'b0}}, pwr_down_o}, '0);
    rd_chk("R6", 12'h000, 8'h00);
    rd_chk("R6", 12'h004, 8'h00);
    wr(12'h004, 8'h01);
    for (int i = 0; i < GB; i += 5) rd_chk("R6", 12'(GBASE + i), 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule